// File: doc/BRIEF.md
# Interleaved Multi-Lane PWM Engine

The engine turns a set of 8-bit duty bytes into on/off enables for a row of channels (18 by default). One period counter, advanced by a prescaler tick taken from the system clock, is shared by every lane. Each lane compares its active duty byte against that counter. A lane is on while its duty is greater than the count, so a duty of N gives N/256 of a period. Lanes can be forced fully on. A blink qualifier can hold a lane off. Pairs of lanes can be moved half a period later, which spreads the turn-on surges across the period.

Duty bytes are given by the host as a staging word and do not act until an update strobe. The staged values are copied into the active bank at the next period wrap, so a period is never cut short. While the engine is shut down the copy happens at once. Each lane also gives a one-clock pulse when its enable falls, so a downstream block can latch new settings at that point. No such pulse is given during the first period after leaving shutdown.

A small sequencer has three states:
- `ST_OFF`: shutdown. All lanes are dark and the counters are held at zero.
- `ST_ARM`: the first period after enabling. Falling pulses are suppressed.
- `ST_RUN`: steady operation.

It has four transitions:
- `T_WAKE`: ST_OFF to ST_ARM when `run_en` is 1.
- `T_SETTLE`: ST_ARM to ST_RUN at a counter wrap.
- `T_SLEEP_A`: ST_ARM to ST_OFF when `run_en` is 0.
- `T_SLEEP_R`: ST_RUN to ST_OFF when `run_en` is 0.

Top module: `pwmx_engine`

## Requirements
- R1: While `rst_n` is low, and right after it, `ch_en` and `ch_fall` are all zero. The active duty bank resets to 0.
- R2: When `run_en` is 0, every bit of `ch_en` and `ch_fall` is 0 from the next clock on. The period counter and the prescaler are held at zero.
- R3: Lane i is on while its active duty is greater than its phase count. A duty of 0 is never on. A duty of 255 is on for 255 of 256 counts. A duty of N is on for N×div clocks per period.
- R4: A 1 in `dc_force[i]` holds lane i on for the whole period, whatever its duty byte, while the engine is running and the lane is not blink-gated.
- R5: `freq_sel`=0 advances the counter once every FAST_DIV clocks. `freq_sel`=1 advances it once every SLOW_DIV clocks. A period is 256 ticks.
- R6: When `phase_en`=1 and `phase_sel[k]`=1, lanes 2k and 2k+1 (0-based) use the phase count (counter+128) mod 256. All other lanes use the plain counter.
- R7: A change on `duty_wr` has no effect until `upd_stb` is pulsed. The staged bank is then copied at the next counter wrap (255→0), or at the next clock if in ST_OFF. Lane i's byte is `duty_wr[8i+7:8i]`.
- R8: When `blink_mode[i]`=1 and `blink_gate[i]`=0, lane i is off, even when `dc_force[i]` is set.
- R9: `ch_fall[i]` is high for exactly one clock, in the clock where `ch_en[i]` has just gone from 1 to 0, in ST_RUN only.
- R10: In the first period after `run_en` rises (ST_ARM), no `ch_fall` pulse is given.
- R11: The sequencer follows T_WAKE, T_SETTLE, T_SLEEP_A and T_SLEEP_R exactly, as seen through the lane outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | 1 = run, 0 = shutdown |
| freq_sel | input | 1 | 0 = fast rate, 1 = slow rate |
| phase_en | input | 1 | Enables pair phase shifting |
| phase_sel | input | NPAIR (9) | Half-period shift per lane pair |
| duty_wr | input | NCH*8 (144) | Staged duty bytes |
| upd_stb | input | 1 | Requests copy of staged duties |
| dc_force | input | NCH (18) | Forces lane fully on |
| blink_mode | input | NCH (18) | Lane uses the blink qualifier |
| blink_gate | input | NCH (18) | Blink on-phase (1 = may light) |
| ch_en | output | NCH (18) | Lane enables |
| ch_fall | output | NCH (18) | One-clock falling-edge pulse |

## Verification
Two cases are hard to reach from the ports:
- A falling pulse in the period right after leaving shutdown.
- A staged duty applied before a wrap.

Both stay silent unless the stimulus lines up a duty edge inside that window. The stimulus therefore drops `run_en` and raises it again with a mid-scale lane running. It then counts falling pulses over exactly the first period and over the period after it. For the staged bank, it changes the staged bytes without a strobe and measures whole periods of on-time both before and after the strobe. A random phase then toggles every control against a cycle model of the requirements.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pwmx_seq.sv
module pwmx_seq
    import pwmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       wrap,
    output seq_state_e state,
    output logic       live,
    output logic       armed
);
    seq_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  if (run_en) nxt = ST_ARM;
            ST_ARM:  if (!run_en) nxt = ST_OFF;
                     else if (wrap) nxt = ST_RUN;
            ST_RUN:  if (!run_en) nxt = ST_OFF;
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        live  = 1'b0;
        armed = 1'b0;
        unique case (state)
            ST_OFF:  begin live = 1'b0; armed = 1'b0; end
            ST_ARM:  begin live = 1'b1; armed = 1'b0; end
            ST_RUN:  begin live = 1'b1; armed = 1'b1; end
            default: begin live = 1'b0; armed = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pwmx_timebase.sv
module pwmx_timebase #(
    parameter int DW       = 8,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          freq_sel,
    output logic [DW-1:0] cnt,
    output logic          wrap
);
    localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PW     = $clog2(MAXDIV) + 1;
    localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
    localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);
    localparam logic [DW-1:0] CMAX     = {DW{1'b1}};

    logic [PW-1:0] pre;
    logic [PW-1:0] lim;
    logic          tick;

    assign lim  = freq_sel ? SLOW_LIM : FAST_LIM;
    assign tick = live && (pre >= lim);
    assign wrap = tick && (cnt == CMAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
            cnt <= '0;
        end else if (!live) begin
            pre <= '0;
            cnt <= '0;
        end else if (tick) begin
            pre <= '0;
            cnt <= cnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/pwmx_duty_bank.sv
module pwmx_duty_bank #(
    parameter int NCH = 18,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  logic              wrap,
    input  logic              upd_stb,
    input  logic [NCH*DW-1:0] staged,
    output logic [NCH*DW-1:0] active
);
    logic pending;
    logic apply_ok;

    assign apply_ok = !live || wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            active  <= '0;
        end else begin
            if (pending && apply_ok) active <= staged;
            if (upd_stb)       pending <= 1'b1;
            else if (apply_ok) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/pwmx_lane.sv
module pwmx_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          armed,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] duty,
    input  logic          shift,
    input  logic          dc,
    input  logic          bl_mode,
    input  logic          bl_gate,
    output logic          en,
    output logic          fall
);
    localparam logic [DW-1:0] HALF = DW'(1) << (DW - 1);

    logic [DW-1:0] pc;
    logic          gate_ok;
    logic          en_q;

    assign pc      = cnt + (shift ? HALF : '0);
    assign gate_ok = !bl_mode || bl_gate;

    always_comb begin
        en = live && gate_ok && (dc || (duty > pc));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    assign fall = armed && en_q && !en;
endmodule

// File: rtl/pwmx_engine.sv
module pwmx_engine
    import pwmx_pkg::*;
#(
    parameter int NCH      = 18,
    parameter int DW       = 8,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 16,
    parameter int NPAIR    = (NCH + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              freq_sel,
    input  logic              phase_en,
    input  logic [NPAIR-1:0]  phase_sel,
    input  logic [NCH*DW-1:0] duty_wr,
    input  logic              upd_stb,
    input  logic [NCH-1:0]    dc_force,
    input  logic [NCH-1:0]    blink_mode,
    input  logic [NCH-1:0]    blink_gate,
    output logic [NCH-1:0]    ch_en,
    output logic [NCH-1:0]    ch_fall
);
    seq_state_e        seq_st;
    logic              live;
    logic              armed;
    logic              wrap;
    logic [DW-1:0]     cnt_q;
    logic [NCH*DW-1:0] act_flat;

    pwmx_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .wrap   (wrap),
        .state  (seq_st),
        .live   (live),
        .armed  (armed)
    );

    pwmx_timebase #(.DW(DW), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .freq_sel (freq_sel),
        .cnt      (cnt_q),
        .wrap     (wrap)
    );

    pwmx_duty_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (live),
        .wrap    (wrap),
        .upd_stb (upd_stb),
        .staged  (duty_wr),
        .active  (act_flat)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_lane
        localparam int PAIR = gi / 2;
        pwmx_lane #(.DW(DW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .live    (live),
            .armed   (armed),
            .cnt     (cnt_q),
            .duty    (act_flat[gi*DW +: DW]),
            .shift   (phase_en && phase_sel[PAIR]),
            .dc      (dc_force[gi]),
            .bl_mode (blink_mode[gi]),
            .bl_gate (blink_gate[gi]),
            .en      (ch_en[gi]),
            .fall    (ch_fall[gi])
        );
    end
endmodule

// File: rtl/pwmx_checker.sv
module pwmx_checker
    import pwmx_pkg::*;
#(
    parameter int NCH = 18,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [NCH-1:0]    dc_force,
    input logic [NCH-1:0]    blink_mode,
    input logic [NCH-1:0]    blink_gate,
    input logic [NCH-1:0]    ch_en,
    input logic [NCH-1:0]    ch_fall,
    input seq_state_e        st,
    input logic [DW-1:0]     cnt,
    input logic              wrap,
    input logic [NCH*DW-1:0] act
);
    logic [NCH-1:0] blocked;
    assign blocked = blink_mode & ~blink_gate;

    assert_off_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (ch_en == '0 && ch_fall == '0));

    assert_force_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF) |-> ((dc_force & ~blocked & ~ch_en) == '0));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) != ST_OFF && !$past(wrap)) |-> $stable(act));

    assert_blink_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked & ch_en) == '0);

    assert_fall_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_fall & ~($past(ch_en) & ~ch_en)) == '0);

    assert_arm_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARM) |-> (ch_fall == '0));

    assert_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && run_en) |=> (st == ST_ARM));
endmodule

bind pwmx_engine pwmx_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .dc_force   (dc_force),
    .blink_mode (blink_mode),
    .blink_gate (blink_gate),
    .ch_en      (ch_en),
    .ch_fall    (ch_fall),
    .st         (seq_st),
    .cnt        (cnt_q),
    .wrap       (wrap),
    .act        (act_flat)
);

// File: tb/pwmx_engine_tb.sv
module pwmx_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 18;
    localparam int NPAIR = 9;
    localparam int FAST = 2;
    localparam int SLOW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic              freq_sel = 1'b0;
    logic              phase_en = 1'b0;
    logic [NPAIR-1:0]  phase_sel = '0;
    logic [NCH*8-1:0]  duty_wr = '0;
    logic              upd_stb = 1'b0;
    logic [NCH-1:0]    dc_force = '0;
    logic [NCH-1:0]    blink_mode = '0;
    logic [NCH-1:0]    blink_gate = '0;
    logic [NCH-1:0]    ch_en;
    logic [NCH-1:0]    ch_fall;

    int checks = 0;
    int fails = 0;
    string cmp_tag = "R1";
    int hi[NCH];
    int fl[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwmx_engine dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .freq_sel(freq_sel),
        .phase_en(phase_en), .phase_sel(phase_sel), .duty_wr(duty_wr),
        .upd_stb(upd_stb), .dc_force(dc_force), .blink_mode(blink_mode),
        .blink_gate(blink_gate), .ch_en(ch_en), .ch_fall(ch_fall)
    );

    // cycle model built from the requirements
    int         m_state = 0;   // 0 off, 1 first period, 2 steady
    int         m_pre = 0;
    logic [7:0] m_cnt = 0;
    logic       m_pend = 0;
    logic [7:0] m_act[NCH];
    logic       m_enq[NCH];

    function automatic logic exp_en(int i);
        logic [7:0] pc;
        if (m_state == 0) return 1'b0;
        if (blink_mode[i] && !blink_gate[i]) return 1'b0;
        if (dc_force[i]) return 1'b1;
        pc = m_cnt + ((phase_en && phase_sel[i/2]) ? 8'd128 : 8'd0);
        return m_act[i] > pc;
    endfunction

    function automatic logic exp_fall(int i);
        return (m_state == 2) && m_enq[i] && !exp_en(i);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin m_act[i] = 0; m_enq[i] = 0; end
    end

    always @(posedge clk) begin
        logic       n_enq[NCH];
        int         lim;
        logic       tick, wrap, ok;
        if (!rst_n) begin
            m_state = 0; m_pre = 0; m_cnt = 0; m_pend = 0;
            for (int i = 0; i < NCH; i++) begin m_act[i] = 0; m_enq[i] = 0; end
        end else begin
            for (int i = 0; i < NCH; i++) n_enq[i] = exp_en(i);
            lim  = freq_sel ? SLOW : FAST;
            tick = (m_state != 0) && (m_pre >= lim - 1);
            wrap = tick && (m_cnt == 8'hFF);
            ok   = (m_state == 0) || wrap;
            if (m_pend && ok)
                for (int i = 0; i < NCH; i++) m_act[i] = duty_wr[i*8 +: 8];
            if (upd_stb) m_pend = 1;
            else if (ok) m_pend = 0;
            for (int i = 0; i < NCH; i++) m_enq[i] = n_enq[i];
            if (m_state == 0) begin m_pre = 0; m_cnt = 0; end
            else if (tick) begin m_pre = 0; m_cnt = m_cnt + 1; end
            else m_pre = m_pre + 1;
            case (m_state)
                0: if (run_en) m_state = 1;
                1: if (!run_en) m_state = 0; else if (wrap) m_state = 2;
                default: if (!run_en) m_state = 0;
            endcase
        end
        #(CLK_PERIOD/4);
        if (rst_n) begin
            logic [NCH-1:0] ee, ef;
            for (int i = 0; i < NCH; i++) begin ee[i] = exp_en(i); ef[i] = exp_fall(i); end
            chk(ch_en == ee && ch_fall == ef, cmp_tag, "model en/fall",
                {ch_en, ch_fall}, {ee, ef});
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(int n);
        for (int i = 0; i < NCH; i++) begin hi[i] = 0; fl[i] = 0; end
        repeat (n) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++) begin
                hi[i] += int'(ch_en[i]);
                fl[i] += int'(ch_fall[i]);
            end
        end
    endtask

    task automatic strobe();
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        cycles(3);
        // R1: reset state
        chk(ch_en == '0 && ch_fall == '0, "R1", "reset outputs", ch_en, 0);
        rst_n = 1'b1;
        cycles(2);
        chk(ch_en == '0 && ch_fall == '0, "R1", "after reset", ch_en, 0);

        // R2: shutdown keeps lanes dark even with duties staged
        cmp_tag = "R2";
        duty_wr[0*8 +: 8] = 8'd0;
        duty_wr[1*8 +: 8] = 8'd255;
        duty_wr[2*8 +: 8] = 8'd128;
        duty_wr[3*8 +: 8] = 8'd1;
        duty_wr[4*8 +: 8] = 8'd128;
        strobe();
        cycles(20);
        chk(ch_en == '0, "R2", "shutdown dark", ch_en, 0);

        // R3 / R9: duty extremes over one full period
        cmp_tag = "R3";
        run_en = 1'b1;
        cycles(600);
        measure(256*FAST);
        chk(hi[0] == 0, "R3", "duty 0 on-time", hi[0], 0);
        chk(hi[1] == 255*FAST, "R3", "duty 255 on-time", hi[1], 255*FAST);
        chk(hi[2] == 128*FAST, "R3", "duty 128 on-time", hi[2], 128*FAST);
        chk(hi[3] == 1*FAST, "R3", "duty 1 on-time", hi[3], FAST);
        chk(fl[1] == 1, "R9", "one fall per period", fl[1], 1);
        chk(fl[0] == 0, "R9", "no fall at duty 0", fl[0], 0);

        // R6: pair 1 (lanes 2,3) shifted half a period against lane 4
        cmp_tag = "R6";
        phase_en = 1'b1;
        phase_sel = 9'b000000010;
        cycles(4);
        for (int k = 0; k < 8; k++) begin
            cycles(37);
            chk(ch_en[2] != ch_en[4], "R6", "shifted lane complements", ch_en[2], !ch_en[4]);
        end
        measure(256*FAST);
        chk(hi[2] == 128*FAST, "R6", "shifted on-time kept", hi[2], 128*FAST);

        // R7: staged duty inert until strobe
        cmp_tag = "R7";
        duty_wr[1*8 +: 8] = 8'd10;
        cycles(3);
        measure(256*FAST);
        chk(hi[1] == 255*FAST, "R7", "no strobe no change", hi[1], 255*FAST);
        strobe();
        cycles(600);
        measure(256*FAST);
        chk(hi[1] == 10*FAST, "R7", "applied after strobe", hi[1], 10*FAST);

        // R5: slow rate stretches the period
        cmp_tag = "R5";
        freq_sel = 1'b1;
        cycles(4200);
        measure(256*SLOW);
        chk(hi[4] == 128*SLOW, "R5", "slow on-time", hi[4], 128*SLOW);
        chk(fl[4] == 1, "R5", "slow one fall", fl[4], 1);
        freq_sel = 1'b0;
        cycles(4200);

        // R4: forced full on
        cmp_tag = "R4";
        dc_force[0] = 1'b1;
        cycles(4);
        measure(256*FAST);
        chk(hi[0] == 256*FAST, "R4", "forced lane always on", hi[0], 256*FAST);
        chk(fl[0] == 0, "R4", "forced lane no fall", fl[0], 0);

        // R8: blink gate blocks even forced lane
        cmp_tag = "R8";
        blink_mode[1] = 1'b1;
        blink_gate[1] = 1'b0;
        dc_force[1] = 1'b1;
        cycles(2);
        measure(256*FAST);
        chk(hi[1] == 0, "R8", "blink off-phase dark", hi[1], 0);
        blink_gate[1] = 1'b1;
        cycles(2);
        chk(ch_en[1] == 1'b1, "R8", "blink on-phase forced", ch_en[1], 1);
        blink_mode[1] = 1'b0;
        dc_force[1] = 1'b0;

        // R10 / R11: leave shutdown, first period silent
        cmp_tag = "R10";
        run_en = 1'b0;
        cycles(5);
        chk(ch_en == '0, "R2", "dark after sleep", ch_en, 0);
        run_en = 1'b1;
        measure(256*FAST);
        chk(fl[4] == 0, "R10", "no fall first period", fl[4], 0);
        chk(hi[4] == 128*FAST, "R10", "first period on-time", hi[4], 128*FAST);
        measure(256*FAST);
        chk(fl[4] == 1, "R11", "fall resumes in steady state", fl[4], 1);

        // R11: random mix against the cycle model
        cmp_tag = "R11";
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            upd_stb = ($urandom % 40) == 0;
            if (($urandom % 10) == 0) duty_wr[($urandom % NCH)*8 +: 8] = 8'($urandom);
            if (($urandom % 50) == 0) dc_force = NCH'($urandom);
            if (($urandom % 20) == 0) blink_mode = NCH'($urandom);
            if (($urandom % 7) == 0) blink_gate = NCH'($urandom);
            if (($urandom % 100) == 0) phase_sel = NPAIR'($urandom);
            if (($urandom % 150) == 0) phase_en = ~phase_en;
            if (($urandom % 400) == 0) freq_sel = ~freq_sel;
            if (($urandom % 300) == 0) run_en = ~run_en;
        end
        upd_stb = 1'b0;
        cycles(2);
        summary();
    end
endmodule